// File: doc/BRIEF.md
# Write Ordering Commit Gate

This block decides, cycle by cycle, whether a store that hits the on-chip writeback cache may commit, or must wait because earlier posted writes from the write-merge buffer are still on their way to the external bus. Each time the merge buffer issues a bus write, the block may arm a single pending flag. While that flag is set, stores to lines in the Modified or Exclusive state are stalled. The flag drops once an external active-low "write buffer empty" input, brought in through a synchronizer, is seen asserted.

A 2-bit ordering mode taken from a configuration register sets how strict the gate is. The upper bit turns ordering off completely. The lower bit, when the upper bit is clear, exempts uncacheable and write-combining bus writes from the rule. Reset selects the strictest setting. Stores to Shared or Invalid lines are never held by this block.

Top module: `wog_commit_gate`

## Requirements
- R1: After reset the mode is 00, no write is pending, and a store request to any line state is granted with stall low.
- R2: While mode bit 1 is 1 (mode 10 or 11), stall is never asserted and no bus write arms the pending flag.
- R3: In mode 01, a bus write of memory type UC (code 00) or WC (code 01) does not arm the pending flag, and a bus write of type WB (code 10) does arm it.
- R4: In mode 00, a bus write of any memory type arms the pending flag on the clock it is issued.
- R5: While the flag is pending, a store request to a Modified (code 11) or Exclusive (code 10) line shows stall high and grant low.
- R6: A store request to a Shared (code 01) or Invalid (code 00) line is granted at once, whether or not a write is pending.
- R7: The active-low empty input passes through two flops. The flag clears on the first clock after arming at which the synchronized value is low, so a stalled request is granted in the cycle after that clock. While the synchronized value is high, the flag holds.
- R8: A qualifying bus write on the same clock as a clear keeps the flag set.
- R9: A mode write takes effect on the next clock. Writing 1x while a write is pending releases a stalled request in the next cycle. Writing 00 again, with the flag still set, stalls again.
- R10: Grant and stall are never high together, and neither is high without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the ordering mode |
| cfg_mode | input | 2 | New mode: bit 1 disables ordering, bit 0 exempts UC/WC |
| flush_vld | input | 1 | Merge buffer issues a bus write this clock |
| flush_type | input | 2 | Memory type of that bus write: 00 UC, 01 WC, 10 WB |
| ext_empty_n | input | 1 | External write-buffer-empty, active low, asynchronous |
| req_vld | input | 1 | A store wants to commit into the cache |
| req_line | input | 2 | State of the target line: 00 I, 01 S, 10 E, 11 M |
| req_grant | output | 1 | The store may commit this cycle |
| req_stall | output | 1 | The store must wait |

## Verification
A pending flag stuck high shows up as a Modified or Exclusive store that stays stalled after the synchronized empty input goes low. The bench detects it in the cycle after the expected clear. A flag that never arms shows up as a grant in the first cycle after a qualifying bus write. A wrong synchronizer depth moves the release one clock early or late, and the cycle-exact release checks catch that. A misdecoded mode or memory type appears as a grant or a stall in the very next request cycle.

// File: rtl/wog_pkg.sv
package wog_pkg;
  localparam int MODE_W = 2;
  localparam int TYPE_W = 2;
  localparam int LINE_W = 2;

  typedef enum logic [TYPE_W-1:0] {MT_UC = 2'b00, MT_WC = 2'b01, MT_WB = 2'b10} mem_type_e;
  typedef enum logic [LINE_W-1:0] {LS_I = 2'b00, LS_S = 2'b01, LS_E = 2'b10, LS_M = 2'b11} line_state_e;

  // Bit 1: ordering off. Bit 0: UC/WC exempt.
  function automatic logic ordering_off(input logic [MODE_W-1:0] mode);
    return mode[1];
  endfunction

  function automatic logic flush_arms(input logic [MODE_W-1:0] mode,
                                      input logic [TYPE_W-1:0] mtype);
    if (ordering_off(mode)) return 1'b0;
    if (mode[0])            return mtype == MT_WB;
    return 1'b1;
  endfunction

  function automatic logic line_gated(input logic [LINE_W-1:0] line);
    return (line == LS_M) || (line == LS_E);
  endfunction
endpackage

// File: rtl/wog_sync.sv
module wog_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage_q[i] <= RST_VAL;
        else if (i == 0) stage_q[i] <= d;
        else             stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wog_pending.sv
module wog_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic drained,
  output logic pending_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= arm | (pending_q & ~drained);
  end
endmodule

// File: rtl/wog_gate.sv
module wog_gate
  import wog_pkg::*;
(
  input  logic [MODE_W-1:0] mode_q,
  input  logic              pending,
  input  logic              req_vld,
  input  logic [LINE_W-1:0] req_line,
  output logic              grant,
  output logic              stall
);
  logic hold;
  always_comb begin
    hold  = pending && !ordering_off(mode_q) && line_gated(req_line);
    stall = req_vld && hold;
    grant = req_vld && !hold;
  end
endmodule

// File: rtl/wog_commit_gate.sv
module wog_commit_gate
  import wog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              flush_vld,
  input  logic [TYPE_W-1:0] flush_type,
  input  logic              ext_empty_n,
  input  logic              req_vld,
  input  logic [LINE_W-1:0] req_line,
  output logic              req_grant,
  output logic              req_stall
);
  logic [MODE_W-1:0] mode_q;
  logic              empty_sync_n;
  logic              flush_qual;
  logic              drained;
  logic              pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (cfg_we) mode_q <= cfg_mode;
  end

  wog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_empty_n), .q(empty_sync_n)
  );

  assign flush_qual = flush_vld && flush_arms(mode_q, flush_type);
  assign drained    = !empty_sync_n;

  wog_pending u_pend (
    .clk(clk), .rst_n(rst_n), .arm(flush_qual), .drained(drained), .pending_q(pending_q)
  );

  wog_gate u_gate (
    .mode_q(mode_q), .pending(pending_q), .req_vld(req_vld), .req_line(req_line),
    .grant(req_grant), .stall(req_stall)
  );
endmodule

// File: rtl/wog_commit_gate_chk.sv
module wog_commit_gate_chk
  import wog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_q,
  input logic              flush_vld,
  input logic [TYPE_W-1:0] flush_type,
  input logic              flush_qual,
  input logic              pending_q,
  input logic              empty_sync_n,
  input logic              req_vld,
  input logic [LINE_W-1:0] req_line,
  input logic              req_grant,
  input logic              req_stall
);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(req_grant && req_stall));
  p_needreq_r10: assert property (@(posedge clk) disable iff (!rst_n) (req_grant || req_stall) |-> req_vld);
  p_global_r2: assert property (@(posedge clk) disable iff (!rst_n) mode_q[1] |-> !req_stall);
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_line == LS_S || req_line == LS_I)) |-> req_grant);
  p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_vld && mode_q == 2'b00) |=> pending_q);
  p_exempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && flush_vld && flush_type != MT_WB && !pending_q) |=> !pending_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !empty_sync_n && !flush_qual) |=> !pending_q);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && empty_sync_n) |=> pending_q);
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !mode_q[1] && req_vld && (req_line == LS_M || req_line == LS_E)) |-> req_stall);
endmodule

bind wog_commit_gate wog_commit_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .flush_vld(flush_vld), .flush_type(flush_type),
  .flush_qual(flush_qual), .pending_q(pending_q), .empty_sync_n(empty_sync_n),
  .req_vld(req_vld), .req_line(req_line), .req_grant(req_grant), .req_stall(req_stall)
);

// File: tb/tb_wog_commit_gate.sv
`timescale 1ns/1ps
module tb_wog_commit_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic flush_vld = 1'b0;
  logic [1:0] flush_type = 2'b10;
  logic ext_empty_n = 1'b1;
  logic req_vld = 1'b0;
  logic [1:0] req_line = 2'b00;
  logic req_grant, req_stall;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wog_commit_gate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .flush_vld(flush_vld), .flush_type(flush_type), .ext_empty_n(ext_empty_n),
    .req_vld(req_vld), .req_line(req_line), .req_grant(req_grant), .req_stall(req_stall)
  );

  // {we, mode[1:0], flush, type[1:0], empty_n, req, line[1:0], exp_grant, exp_stall}
  // types: UC 00, WC 01, WB 10; lines: I 00, S 01, E 10, M 11
  localparam int NV = 31;
  localparam logic [11:0] VEC [NV] = '{
    12'b0_00_0_10_1_1_11_1_0, // 0  R1 idle grant
    12'b0_00_1_10_1_0_00_0_0, // 1  R4 WB flush arms
    12'b0_00_0_10_1_1_11_0_1, // 2  R5 M stalled
    12'b0_00_0_10_1_1_01_1_0, // 3  R6 S passes
    12'b0_00_0_10_1_1_00_1_0, // 4  R6 I passes
    12'b0_00_0_10_0_1_10_0_1, // 5  R7 empty low, stage 1
    12'b0_00_0_10_0_1_11_0_1, // 6  R7 stage 2
    12'b0_00_0_10_0_1_11_0_1, // 7  R7 clears this clock
    12'b0_00_0_10_0_1_11_1_0, // 8  R7 released
    12'b0_00_1_00_0_0_00_0_0, // 9  R4 UC arms in mode 00
    12'b0_00_0_10_0_1_10_0_1, // 10 R7 first later clock clears
    12'b0_00_0_10_0_1_10_1_0, // 11 R7 released
    12'b0_00_1_10_0_0_00_0_0, // 12 R8 arm
    12'b0_00_1_10_0_1_11_0_1, // 13 R8 arm with clear
    12'b0_00_0_10_0_1_11_0_1, // 14 R8 still pending
    12'b0_00_0_10_0_1_11_1_0, // 15 R7 released
    12'b1_01_0_10_1_0_00_0_0, // 16 R9 write mode 01
    12'b0_00_1_00_1_1_11_1_0, // 17 R3 UC exempt
    12'b0_00_1_01_1_1_11_1_0, // 18 R3 WC exempt
    12'b0_00_1_10_1_1_11_1_0, // 19 R3 WB arms
    12'b0_00_0_10_1_1_11_0_1, // 20 R3 stalled
    12'b0_00_0_10_1_1_01_1_0, // 21 R6 S passes
    12'b1_10_0_10_1_1_11_0_1, // 22 R9 write 10, old mode this cycle
    12'b0_00_0_10_1_1_11_1_0, // 23 R9 released
    12'b0_00_1_10_1_1_10_1_0, // 24 R2 flush ignored
    12'b1_11_0_10_1_1_11_1_0, // 25 R2 write 11
    12'b1_00_0_10_1_1_11_1_0, // 26 R2 write 00
    12'b0_00_0_10_0_1_11_0_1, // 27 R9 flag still set
    12'b0_00_0_10_0_1_11_0_1, // 28 R7
    12'b0_00_0_10_0_1_11_0_1, // 29 R7 clears
    12'b0_00_0_10_0_1_11_1_0  // 30 R7 released
  };
  localparam int TAG [NV] = '{1,4,5,6,6,7,7,7,7,4,7,7,8,8,8,7,9,3,3,3,3,6,9,9,2,2,2,9,7,7,7};

  task automatic check(input int rq, input logic g, input logic s, input logic eg, input logic es);
    checks++;
    if (g !== eg || s !== es) begin
      errors++;
      $display("FAIL R%0d: grant=%b stall=%b expected grant=%b stall=%b", rq, g, s, eg, es);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] m, input logic fv, input logic [1:0] ft,
                       input logic en, input logic rv, input logic [1:0] ln);
    cfg_we = we; cfg_mode = m; flush_vld = fv; flush_type = ft;
    ext_empty_n = en; req_vld = rv; req_line = ln;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(1, req_grant, req_stall, 1'b0, 1'b0); // R1 no request, nothing out
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][11], VEC[i][10:9], VEC[i][8], VEC[i][7:6], VEC[i][5], VEC[i][4], VEC[i][3:2]);
      #1 check(TAG[i], req_grant, req_stall, VEC[i][1], VEC[i][0]);
    end

    // R1: reset while pending in mode 01 returns to mode 00 with nothing pending
    @(negedge clk); drive(1, 2'b01, 0, 2'b10, 1, 0, 2'b00);
    @(negedge clk); drive(0, 2'b00, 1, 2'b10, 1, 0, 2'b00);
    @(negedge clk); drive(0, 2'b00, 0, 2'b10, 1, 1, 2'b11);
    #1 check(5, req_grant, req_stall, 1'b0, 1'b1);
    rst_n = 1'b0;
    #1 check(1, req_grant, req_stall, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    drive(0, 2'b00, 1, 2'b00, 1, 1, 2'b11);
    #1 check(1, req_grant, req_stall, 1'b1, 1'b0);
    @(negedge clk); drive(0, 2'b00, 0, 2'b00, 1, 1, 2'b10);
    #1 check(1, req_grant, req_stall, 1'b0, 1'b1); // R1 mode back to 00: UC armed

    // R7: a one-clock low pulse on the empty input still releases, 3 clocks later
    @(negedge clk); drive(0, 2'b00, 0, 2'b00, 0, 1, 2'b11);
    #1 check(7, req_grant, req_stall, 1'b0, 1'b1);
    @(negedge clk); drive(0, 2'b00, 0, 2'b00, 1, 1, 2'b11);
    #1 check(7, req_grant, req_stall, 1'b0, 1'b1);
    @(negedge clk);
    #1 check(7, req_grant, req_stall, 1'b0, 1'b1);
    @(negedge clk);
    #1 check(7, req_grant, req_stall, 1'b1, 1'b0);
    @(negedge clk); drive(0, 2'b00, 0, 2'b00, 1, 0, 2'b11);
    #1 check(10, req_grant, req_stall, 1'b0, 1'b0); // R10 no request

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule